// File: doc/BRIEF.md
# Aggregated POLYVAL Hash Engine

This block computes the POLYVAL universal hash of a stream of 128-bit blocks under a 128-bit key h. Loading a key starts a short derivation phase that fills a table with the field powers h^1 up to h^GROUP (GROUP is 8 by default). Each power comes from the one below it through one Montgomery multiply by h. No blocks are taken during this phase. After that, message blocks enter through a valid/ready port. They are buffered until a full group of GROUP blocks is held, or until the message ends.

The buffered group is then multiplied out with one 128x128 carryless product per cycle. Block j of a group of k blocks is paired with h^(k-j). The 256-bit products are XOR-summed without reduction, and the sum receives a single Montgomery fold when the group ends. The running accumulator is XORed into the first block of every group, so no separate multiply is spent on it. When the last group has been folded, the digest is presented together with a one-cycle done pulse.

A message starts with its first accepted beat. The starting accumulator is sampled at that beat. A beat with the void flag set carries no block. A message made of a single void beat with the last flag set is an empty message.

Top module: `polyval_agg_engine`

## Requirements
- R1: The digest of a message of n blocks m_0..m_(n-1) with starting accumulator a equals the one-block-at-a-time result. That result starts from s = a and repeats s = dot(s XOR m_j, h) for every block, where dot(x, y) = x·y·x^-128 mod x^128 + x^127 + x^126 + x^121 + 1.
- R2: A key is accepted (key_valid and key_ready) only when no message is open. After acceptance, blk_ready stays low for exactly GROUP-1 cycles while the powers h^2..h^GROUP are derived.
- R3: For messages longer than one group, the reduced value of each full group is carried into the first block of the next group. The result still matches R1.
- R4: A final group of k blocks, with 0 < k < GROUP, uses the powers h^k down to h^1 and is folded once. Its result matches R1.
- R5: When the block count is a multiple of GROUP, the fold of the last full group is the digest. This holds whether the final block carries the last flag or a separate void beat carrying the last flag ends the message.
- R6: An empty message (a first beat with blk_last=1 and blk_void=1) returns acc_init unchanged, with done high in the cycle after that beat is accepted.
- R7: Polynomial coefficient x^i sits at bit i of every 128-bit value. Byte j of a 16-byte string occupies bits 8j+7:8j.
- R8: done is high for exactly one cycle per message. digest changes only in a cycle where done is high and holds its value otherwise. After reset, done is 0 and digest is 0.
- R9: A beat with blk_void=1 and blk_last=0 adds no block and leaves the digest unchanged.
- R10: In the cycle after a beat with blk_last=1 is accepted, blk_ready is low.
- R11: Loading a new key between messages replaces h and all of its powers for the messages that follow.
- R12: acc_init is sampled only at the first accepted beat of a message. Later changes to it do not affect that message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | Key offered |
| key_ready | output | 1 | Key can be accepted (no key yet, or between messages) |
| key_data | input | 128 | Hash key h |
| acc_init | input | 128 | Starting accumulator, sampled at the first beat of a message |
| blk_valid | input | 1 | Block beat offered |
| blk_ready | output | 1 | Block beat can be accepted |
| blk_data | input | 128 | Message block |
| blk_last | input | 1 | Final beat of the message |
| blk_void | input | 1 | Beat carries no block |
| digest | output | 128 | Hash result, updated when done is high |
| done | output | 1 | One-cycle pulse, digest valid |

## Verification
Every block count from 1 to 20 is compared against a one-block-at-a-time reference. This covers partial groups only, exact single and double groups, and full groups followed by a remainder, so it separates wrong power pairing from a lost carry between groups. An empty message, void terminators after exact multiples, void beats inside a message and changes to acc_init in the middle of a message show whether the bookkeeping between beats and blocks is right. A published key and two-block vector pins the bit and byte ordering. A key reload shows that every power is rebuilt.

// File: rtl/polyval_pkg.sv
package polyval_pkg;
    localparam int BW = 128;
    localparam int PW = 2 * BW;

    typedef logic [BW-1:0] blk_t;
    typedef logic [PW-1:0] wide_t;

    typedef enum logic [1:0] {ST_NOKEY, ST_KEYGEN, ST_COLLECT, ST_MULT} st_e;

    // Field modulus x^128 + x^127 + x^126 + x^121 + 1, one bit per coefficient
    localparam wide_t GPOLY = (wide_t'(1) << 128) | (wide_t'(1) << 127) |
                              (wide_t'(1) << 126) | (wide_t'(1) << 121) | wide_t'(1);
endpackage

// File: rtl/pv_clmul.sv
module pv_clmul
    import polyval_pkg::*;
(
    input  blk_t  a_i,
    input  blk_t  b_i,
    output wide_t p_o
);
    wide_t part;

    // Carryless product: XOR of shifted copies of a_i selected by b_i bits
    always_comb begin
        part = '0;
        for (int i = 0; i < BW; i++) begin
            if (b_i[i]) part = part ^ (wide_t'(a_i) << i);
        end
        p_o = part;
    end
endmodule

// File: rtl/pv_fold.sv
module pv_fold
    import polyval_pkg::*;
(
    input  wide_t p_i,
    output blk_t  r_o
);
    wide_t work;

    // Cancel the low half with multiples of the modulus, then keep the top half,
    // which divides by x^128 and leaves a result below degree 128
    always_comb begin
        work = p_i;
        for (int i = 0; i < BW; i++) begin
            if (work[i]) work = work ^ (GPOLY << i);
        end
        r_o = work[PW-1:BW];
    end
endmodule

// File: rtl/pv_power_table.sv
module pv_power_table
    import polyval_pkg::*;
#(
    parameter int NPOW = 8,
    parameter int IW   = $clog2(NPOW)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  blk_t                     wr_data,
    output logic [NPOW-1:0][BW-1:0]  pow_o
);
    logic [NPOW-1:0][BW-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) tbl_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign pow_o = tbl_q;
endmodule

// File: rtl/polyval_agg_engine.sv
module polyval_agg_engine
    import polyval_pkg::*;
#(
    parameter int GROUP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_valid,
    output logic          key_ready,
    input  logic [127:0]  key_data,
    input  logic [127:0]  acc_init,
    input  logic          blk_valid,
    output logic          blk_ready,
    input  logic [127:0]  blk_data,
    input  logic          blk_last,
    input  logic          blk_void,
    output logic [127:0]  digest,
    output logic          done
);
    localparam int CW = $clog2(GROUP + 1);
    localparam int IW = $clog2(GROUP);

    typedef struct packed {
        st_e                      st;
        logic [CW-1:0]            cnt;
        logic [CW-1:0]            idx;
        logic [CW-1:0]            step;
        logic                     in_msg;
        logic                     last_seen;
        logic                     done;
        blk_t                     run;
        blk_t                     dig;
        wide_t                    sum;
        logic [GROUP-1:0][BW-1:0] blks;
    } core_t;

    core_t r_d, r_q;

    logic [GROUP-1:0][BW-1:0] pow_tbl;
    logic                     pw_we;
    logic [IW-1:0]            pw_widx;
    blk_t                     pw_wdata;
    blk_t                     mul_a, mul_b, fold_out;
    wide_t                    prod, sum_new, fold_in;
    logic [IW-1:0]            kg_rd, mt_rd, buf_rd;
    logic                     first;

    pv_power_table #(.NPOW(GROUP), .IW(IW)) u_pow (
        .clk(clk), .rst_n(rst_n), .wr_en(pw_we), .wr_idx(pw_widx),
        .wr_data(pw_wdata), .pow_o(pow_tbl)
    );
    pv_clmul u_mul (.a_i(mul_a), .b_i(mul_b), .p_o(prod));
    pv_fold  u_fold (.p_i(fold_in), .r_o(fold_out));

    // Operand selection for the single shared multiplier
    always_comb begin
        kg_rd  = IW'(r_q.step - CW'(2));            // power h^(step-1)
        mt_rd  = IW'(r_q.cnt - r_q.idx - CW'(1));   // power h^(cnt-idx)
        buf_rd = IW'(r_q.idx);
        first  = (r_q.idx == '0);
        if (r_q.st == ST_KEYGEN) begin
            mul_a = pow_tbl[0];
            mul_b = pow_tbl[kg_rd];
        end else begin
            mul_a = r_q.blks[buf_rd] ^ (first ? r_q.run : '0);
            mul_b = pow_tbl[mt_rd];
        end
        sum_new = (first ? '0 : r_q.sum) ^ prod;
        fold_in = (r_q.st == ST_KEYGEN) ? prod : sum_new;
    end

    // Next-state process
    always_comb begin
        logic [CW-1:0] cnt_n;
        blk_t          base_run;
        r_d       = r_q;
        r_d.done  = 1'b0;
        pw_we     = 1'b0;
        pw_widx   = '0;
        pw_wdata  = key_data;
        cnt_n     = r_q.cnt;
        base_run  = r_q.in_msg ? r_q.run : acc_init;
        key_ready = (r_q.st == ST_NOKEY) ||
                    (r_q.st == ST_COLLECT && !r_q.in_msg && !r_q.done);
        blk_ready = (r_q.st == ST_COLLECT) && !r_q.done && !(key_valid && key_ready);

        case (r_q.st)
            ST_NOKEY, ST_COLLECT: begin
                if (key_valid && key_ready) begin
                    pw_we    = 1'b1;
                    pw_widx  = '0;
                    pw_wdata = key_data;
                    r_d.st   = ST_KEYGEN;
                    r_d.step = CW'(2);
                end else if (blk_valid && blk_ready) begin
                    r_d.run    = base_run;
                    r_d.in_msg = 1'b1;
                    if (!blk_void) begin
                        r_d.blks[IW'(r_q.cnt)] = blk_data;
                        cnt_n = r_q.cnt + CW'(1);
                    end
                    r_d.cnt       = cnt_n;
                    r_d.last_seen = blk_last;
                    if (blk_last && cnt_n == '0) begin
                        r_d.dig       = base_run;
                        r_d.done      = 1'b1;
                        r_d.in_msg    = 1'b0;
                        r_d.last_seen = 1'b0;
                    end else if (blk_last || cnt_n == CW'(GROUP)) begin
                        r_d.st  = ST_MULT;
                        r_d.idx = '0;
                    end
                end
            end
            ST_KEYGEN: begin
                pw_we    = 1'b1;
                pw_widx  = IW'(r_q.step - CW'(1));
                pw_wdata = fold_out;
                r_d.step = r_q.step + CW'(1);
                if (r_q.step == CW'(GROUP)) r_d.st = ST_COLLECT;
            end
            ST_MULT: begin
                r_d.sum = sum_new;
                if (r_q.idx == r_q.cnt - CW'(1)) begin
                    r_d.run = fold_out;
                    r_d.cnt = '0;
                    r_d.st  = ST_COLLECT;
                    if (r_q.last_seen) begin
                        r_d.dig       = fold_out;
                        r_d.done      = 1'b1;
                        r_d.in_msg    = 1'b0;
                        r_d.last_seen = 1'b0;
                    end
                end else begin
                    r_d.idx = r_q.idx + CW'(1);
                end
            end
            default: r_d.st = ST_NOKEY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_NOKEY;
        end else begin
            r_q    <= r_d;
        end
    end

    assign digest = r_q.dig;
    assign done   = r_q.done;

    // R8: done never lasts two cycles
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: digest only moves together with done
    p_digest_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(digest));
    // R2: block input stalls right after a key is taken
    p_stall_on_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_ready) |=> !blk_ready);
    // R6: empty message returns the starting accumulator
    p_empty_msg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_ready && blk_last && blk_void && !r_q.in_msg)
        |=> (done && digest == $past(acc_init)));
    // R10: no beat is taken in the cycle after a final beat
    p_last_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_ready && blk_last) |=> !blk_ready);
endmodule

// File: tb/polyval_agg_engine_bench.sv
`timescale 1ns/1ps
module polyval_agg_engine_bench;
    localparam int G = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_valid = 1'b0, key_ready;
    logic [127:0] key_data = '0, acc_init = '0, blk_data = '0, digest;
    logic         blk_valid = 1'b0, blk_ready, blk_last = 1'b0, blk_void = 1'b0, done;

    always #2.5 clk = ~clk;

    polyval_agg_engine #(.GROUP(G)) u_polyval_agg_engine (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
        .key_data(key_data), .acc_init(acc_init), .blk_valid(blk_valid),
        .blk_ready(blk_ready), .blk_data(blk_data), .blk_last(blk_last),
        .blk_void(blk_void), .digest(digest), .done(done)
    );

    int n_chk = 0, n_bad = 0, n_done = 0;
    bit started = 0, prev_done = 0;
    logic [127:0] prev_dig = '0, last_dig = '0, cur_key = '0;
    logic [127:0] exp_q[$];
    string        tag_q[$];
    logic [127:0] cur_blks[$];

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // Bit-serial Montgomery product: a*b*x^-128 mod the field polynomial
    function automatic logic [127:0] ref_dot(input logic [127:0] a, input logic [127:0] b);
        logic [128:0] r = '0;
        logic [128:0] g = (129'd1 << 128) | (129'd1 << 127) | (129'd1 << 126) |
                          (129'd1 << 121) | 129'd1;
        for (int i = 0; i < 128; i++) begin
            if (b[i]) r = r ^ {1'b0, a};
            if (r[0]) r = r ^ g;
            r = r >> 1;
        end
        return r[127:0];
    endfunction

    function automatic logic [127:0] bswap(input logic [127:0] x);
        logic [127:0] r;
        for (int j = 0; j < 16; j++) r[8*j +: 8] = x[8*(15-j) +: 8];
        return r;
    endfunction

    // Per-clock monitor: digest pairing, one-cycle done, digest hold (R8)
    always @(negedge clk) begin
        if (started) begin
            if (done) begin
                if (prev_done) check(0, "R8 done longer than one cycle", 128'(done), 128'(0));
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected done", digest, prev_dig);
                end else begin
                    check(digest == exp_q[0], tag_q[0], digest, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
                last_dig = digest;
                n_done++;
            end else begin
                check(digest == prev_dig, "R8 digest moved without done", digest, prev_dig);
            end
            prev_done = done;
            prev_dig  = digest;
        end
    end

    task automatic send_beat(input logic [127:0] d, input bit last, input bit vd);
        blk_valid = 1'b1; blk_data = d; blk_last = last; blk_void = vd;
        #0.1;
        while (!blk_ready) @(negedge clk);
        @(negedge clk);
        blk_valid = 1'b0; blk_last = 1'b0; blk_void = 1'b0;
    endtask

    task automatic load_key(input logic [127:0] k, input string tag);
        int c = 0;
        key_valid = 1'b1; key_data = k;
        #0.1;
        while (!key_ready) @(negedge clk);
        @(negedge clk);
        key_valid = 1'b0;
        cur_key = k;
        while (!blk_ready && c < 50) begin
            c++;
            @(negedge clk);
        end
        check(c == G - 1, tag, 128'(c), 128'(G - 1));
    endtask

    // Sends cur_blks as one message; gaps inserts void beats, vterm ends with a void beat
    task automatic run_msg(input logic [127:0] init, input bit vterm, input bit gaps,
                           input string tag);
        int n = cur_blks.size();
        int w = 0, start;
        logic [127:0] s = init;
        for (int j = 0; j < n; j++) s = ref_dot(s ^ cur_blks[j], cur_key);
        exp_q.push_back(s);
        tag_q.push_back(tag);
        start = n_done;
        acc_init = init;
        for (int j = 0; j < n; j++) begin
            if (gaps && (j % 3 == 1)) send_beat(rnd128(), 1'b0, 1'b1);   // R9 void beats
            send_beat(cur_blks[j], (j == n - 1) && !vterm, 1'b0);
            acc_init = rnd128();                                      // R12 late change
        end
        if (vterm || n == 0) send_beat(rnd128(), 1'b1, 1'b1);
        check(blk_ready == 1'b0, {tag, " R10 ready after last"}, 128'(blk_ready), 128'(0));
        while (n_done == start && w < 300) begin
            w++;
            @(negedge clk);
        end
        if (n_done == start) check(0, {tag, " no done"}, 128'(0), s);
    endtask

    task automatic fill_rand(input int n);
        cur_blks.delete();
        for (int j = 0; j < n; j++) cur_blks.push_back(rnd128());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [127:0] kv, pv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        started = 1;
        // R8 reset state, R2 no blocks before a key
        check(done == 1'b0,      "R8 reset done",     128'(done), 128'(0));
        check(digest == '0,      "R8 reset digest",   digest, 128'(0));
        check(blk_ready == 1'b0, "R2 reset blk_ready", 128'(blk_ready), 128'(0));
        check(key_ready == 1'b1, "R2 reset key_ready", 128'(key_ready), 128'(1));

        // R7 published vector, byte strings mapped with byte j at bits 8j+7:8j
        kv = bswap(128'h25629347589242761d31f826ba4b757b);
        pv = bswap(128'hf7a3b47b846119fae5b7866cf5e5b77e);
        load_key(kv, "R2 keygen stall");
        cur_blks.delete();
        cur_blks.push_back(bswap(128'h4f4f95668c83dfb6401762bb2d01a262));
        cur_blks.push_back(bswap(128'hd1a24ddd2721d006bbe45f20d3c9f362));
        run_msg('0, 1'b0, 1'b0, "R7 vector vs model");
        check(last_dig == pv, "R7 vector vs published", last_dig, pv);

        // R1 R3 R4 R5 every count from 1 to 20
        load_key(rnd128(), "R2 keygen stall");
        for (int n = 1; n <= 20; n++) begin
            fill_rand(n);
            if (n < G)            run_msg(rnd128(), 1'b0, 1'b0, "R1 R4 partial group");
            else if (n % G == 0)  run_msg(rnd128(), 1'b0, 1'b0, "R1 R5 exact groups");
            else                  run_msg(rnd128(), 1'b0, 1'b0, "R1 R3 carried groups");
        end

        // R6 empty message
        fill_rand(0);
        run_msg(rnd128(), 1'b1, 1'b0, "R6 empty message");
        // R5 void terminator after exact multiples
        fill_rand(16);
        run_msg(rnd128(), 1'b1, 1'b0, "R5 void terminator");
        fill_rand(8);
        run_msg(rnd128(), 1'b1, 1'b0, "R5 void terminator");
        fill_rand(3);
        run_msg(rnd128(), 1'b1, 1'b0, "R4 void terminator");
        // R9 void beats inside the message
        fill_rand(6);
        run_msg(rnd128(), 1'b0, 1'b1, "R9 void beats");
        fill_rand(13);
        run_msg(rnd128(), 1'b0, 1'b1, "R9 void beats");
        // R12 acc_init changes after the first beat (done inside run_msg)
        fill_rand(10);
        run_msg(rnd128(), 1'b0, 1'b0, "R12 acc_init sampled once");
        // R11 rekey between messages
        load_key(rnd128(), "R11 R2 rekey stall");
        fill_rand(9);
        run_msg(rnd128(), 1'b0, 1'b0, "R11 new key");
        fill_rand(1);
        run_msg(rnd128(), 1'b0, 1'b0, "R11 new key");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R8 missing done", 128'(exp_q.size()), 128'(0));
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule